// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit settles a conditional relative branch in one step. It receives the branch opcode word, the displacement word, the address of the branch instruction, the four status flags and a 4-bit external condition input. From these it decides whether the branch is taken and computes the address of the next instruction. Both results are registered, so they appear one clock after the inputs are presented.

The displacement word is an unsigned magnitude. A direction bit in the opcode says whether the jump goes forward or backward, and the two directions use different base offsets. A mode bit in the opcode chooses what the branch tests. In flag mode it tests one of eight flag conditions, and the top condition bit inverts that test. In external mode it tests whether the condition field equals the external input. The block does not fetch the displacement word and does not hold the register file. It is fed every cycle, and a new branch may be presented every cycle.

Top module: `br_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, `taken_o` becomes 0 and `next_pc_o` becomes 0 after that edge.
- R2: Outputs are registered. The values seen after a rising edge are computed from the inputs sampled at that edge.
- R3: With opcode bit 4 (mode) clear and condition field `opcode_i[3:0]` equal to 4'b0000, the branch is always taken.
- R4: With the mode bit clear and inversion bit `opcode_i[3]` clear, the low three condition bits select the test. The flag bits are `flags_i[3]`=S, `[2]`=Z, `[1]`=O and `[0]`=C. The tests are: 001 C; 010 O; 011 not S; 100 Z; 101 S xor O; 110 Z or (S xor O); 111 S xor C.
- R5: With the mode bit clear and `opcode_i[3]` set, the result is the inverse of the test picked by bits 2:0. In particular, code 4'b1000 is never taken, and `next_pc_o` is then the branch address plus 2.
- R6: With the mode bit `opcode_i[4]` set, the branch is taken exactly when `opcode_i[3:0]` equals `ext_cond_i`. The flags have no effect in this mode.
- R7: A taken branch with direction bit `opcode_i[5]` clear gives `next_pc_o` = branch address + 2 + displacement.
- R8: A taken branch with direction bit `opcode_i[5]` set gives `next_pc_o` = branch address + 1 - displacement.
- R9: A branch that is not taken gives `next_pc_o` = branch address + 2, whatever the displacement and direction.
- R10: All address arithmetic wraps modulo 2^16.
- R11: Opcode bits 9:6 are not decoded and have no effect. In flag mode, `ext_cond_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 10 | Branch opcode word: [5] direction, [4] mode, [3:0] condition field |
| disp_i | input | 16 | Unsigned displacement magnitude |
| br_addr_i | input | 16 | Address of the branch instruction |
| flags_i | input | 4 | Status flags: S, Z, O, C from bit 3 down to bit 0 |
| ext_cond_i | input | 4 | External condition value, compared in external mode |
| taken_o | output | 1 | Branch taken, registered |
| next_pc_o | output | 16 | Address of the next instruction, registered |

## Verification
The bench builds two copies of the block with the default 16-bit address and 4-bit condition widths. The two copies differ only in `TARGET_STYLE`: style 0 forms the target with one adder and a conditional inversion of the displacement, and style 1 uses two adders and a select. Both copies are checked against the same behavioural model on every cycle, so either target formula fails on a mismatch in forward, backward or wrapping cases. The stimulus is random over all sixteen codes in both modes, with the flags and the external input varied independently. Directed steps cover wrap-around at 0x0000 and 0xFFFF, a zero displacement, the never code, and toggling of the undecoded opcode bits.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int unsigned BR_ADDR_W = 16;
    localparam int unsigned BR_COND_W = 4;
    localparam int unsigned BR_OPC_W  = 10;

    typedef struct packed {
        logic s;
        logic z;
        logic o;
        logic c;
    } br_flags_t;

    typedef enum logic [2:0] {
        TST_ALWAYS = 3'd0,
        TST_CARRY  = 3'd1,
        TST_OVF    = 3'd2,
        TST_PLUS   = 3'd3,
        TST_ZERO   = 3'd4,
        TST_LESS   = 3'd5,
        TST_LEQ    = 3'd6,
        TST_SXC    = 3'd7
    } br_test_e;

    function automatic logic br_flag_test(br_test_e sel, br_flags_t f);
        logic r;
        unique case (sel)
            TST_ALWAYS: r = 1'b1;
            TST_CARRY:  r = f.c;
            TST_OVF:    r = f.o;
            TST_PLUS:   r = ~f.s;
            TST_ZERO:   r = f.z;
            TST_LESS:   r = f.s ^ f.o;
            TST_LEQ:    r = f.z | (f.s ^ f.o);
            TST_SXC:    r = f.s ^ f.c;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
#(
    parameter int unsigned COND_W = BR_COND_W
) (
    input  logic [COND_W-1:0] cond_i,
    input  logic              ext_mode_i,
    input  logic [COND_W-1:0] ext_cond_i,
    input  br_flags_t         flags_i,
    output logic              take_o
);

    localparam int unsigned INV_BIT = COND_W - 1;

    br_test_e test_sel;
    logic     flag_hit;
    logic     ext_hit;

    assign test_sel = br_test_e'(cond_i[2:0]);
    assign flag_hit = br_flag_test(test_sel, flags_i) ^ cond_i[INV_BIT];
    assign ext_hit  = (cond_i == ext_cond_i);

    always_comb begin
        if (ext_mode_i) begin
            take_o = ext_hit;
        end else begin
            take_o = flag_hit;
        end
    end

endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
    import br_pkg::*;
#(
    parameter int unsigned ADDR_W       = BR_ADDR_W,
    parameter int unsigned TARGET_STYLE = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic              back_i,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] fall_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    assign fall_o = addr_i + TWO;

    generate
        if (TARGET_STYLE == 0) begin : g_xor_form
            // addr + 1 - d equals addr + 2 + ~d, so one adder serves both directions
            logic [ADDR_W-1:0] disp_adj;
            assign disp_adj = disp_i ^ {ADDR_W{back_i}};
            assign target_o = fall_o + disp_adj;
        end else begin : g_mux_form
            logic [ADDR_W-1:0] fwd_t;
            logic [ADDR_W-1:0] bwd_t;
            assign fwd_t    = fall_o + disp_i;
            assign bwd_t    = (addr_i + ONE) - disp_i;
            assign target_o = back_i ? bwd_t : fwd_t;
        end
    endgenerate

endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_pkg::*;
#(
    parameter int unsigned ADDR_W       = BR_ADDR_W,
    parameter int unsigned COND_W       = BR_COND_W,
    parameter int unsigned OPC_W        = BR_OPC_W,
    parameter int unsigned TARGET_STYLE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] br_addr_i,
    input  logic [3:0]        flags_i,
    input  logic [COND_W-1:0] ext_cond_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam int unsigned MODE_BIT = COND_W;
    localparam int unsigned DIR_BIT  = COND_W + 1;

    logic [COND_W-1:0] cond_fld;
    logic              mode_ext;
    logic              dir_back;
    logic              take_d;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] fall;
    logic [ADDR_W-1:0] next_d;
    logic              unused_opc_hi;

    assign cond_fld      = opcode_i[COND_W-1:0];
    assign mode_ext      = opcode_i[MODE_BIT];
    assign dir_back      = opcode_i[DIR_BIT];
    assign unused_opc_hi = ^opcode_i[OPC_W-1:DIR_BIT+1];

    br_cond_eval #(
        .COND_W (COND_W)
    ) u_cond (
        .cond_i     (cond_fld),
        .ext_mode_i (mode_ext),
        .ext_cond_i (ext_cond_i),
        .flags_i    (br_flags_t'(flags_i)),
        .take_o     (take_d)
    );

    br_target_calc #(
        .ADDR_W       (ADDR_W),
        .TARGET_STYLE (TARGET_STYLE)
    ) u_tgt (
        .addr_i   (br_addr_i),
        .disp_i   (disp_i),
        .back_i   (dir_back),
        .target_o (target),
        .fall_o   (fall)
    );

    assign next_d = take_d ? target : fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
        end else begin
            taken_o   <= take_d;
            next_pc_o <= next_d;
        end
    end

endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned COND_W = 4,
    parameter int unsigned OPC_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [OPC_W-1:0]  opcode_i,
    input logic [ADDR_W-1:0] disp_i,
    input logic [ADDR_W-1:0] br_addr_i,
    input logic [3:0]        flags_i,
    input logic [COND_W-1:0] ext_cond_i,
    input logic              taken_o,
    input logic [ADDR_W-1:0] next_pc_o
);

    logic seen;
    logic unused_chk;

    assign unused_chk = ^flags_i;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R1
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!taken_o && next_pc_o == '0));

    // R9
    p_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (seen && !taken_o) |-> (next_pc_o == $past(br_addr_i) + ADDR_W'(2)));

    // R7
    p_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        (seen && taken_o && !$past(opcode_i[COND_W+1]))
        |-> (next_pc_o == $past(br_addr_i) + ADDR_W'(2) + $past(disp_i)));

    // R8
    p_bwd_r8: assert property (@(posedge clk) disable iff (rst)
        (seen && taken_o && $past(opcode_i[COND_W+1]))
        |-> (next_pc_o == $past(br_addr_i) + ADDR_W'(1) - $past(disp_i)));

    // R6
    p_ext_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(opcode_i[COND_W]))
        |-> (taken_o == ($past(opcode_i[COND_W-1:0]) == $past(ext_cond_i))));

    // R3
    p_always_r3: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(opcode_i[COND_W]) && $past(opcode_i[COND_W-1:0]) == '0)
        |-> taken_o);

    // R5
    p_never_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(opcode_i[COND_W]) && $past(opcode_i[COND_W-1:0]) == COND_W'(8))
        |-> !taken_o);

endmodule

bind br_resolve br_resolve_chk #(
    .ADDR_W (ADDR_W),
    .COND_W (COND_W),
    .OPC_W  (OPC_W)
) u_br_resolve_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode_i   (opcode_i),
    .disp_i     (disp_i),
    .br_addr_i  (br_addr_i),
    .flags_i    (flags_i),
    .ext_cond_i (ext_cond_i),
    .taken_o    (taken_o),
    .next_pc_o  (next_pc_o)
);

// File: tb/test_br_resolve.sv
module test_br_resolve;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  opcode = '0;
    logic [15:0] disp = '0;
    logic [15:0] addr = '0;
    logic [3:0]  flags = '0;
    logic [3:0]  ext = '0;
    logic        taken_a, taken_b;
    logic [15:0] npc_a, npc_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolve i_br_resolve (
        .clk(clk), .rst(rst), .opcode_i(opcode), .disp_i(disp),
        .br_addr_i(addr), .flags_i(flags), .ext_cond_i(ext),
        .taken_o(taken_a), .next_pc_o(npc_a)
    );

    br_resolve #(.TARGET_STYLE(1)) i_br_resolve_alt (
        .clk(clk), .rst(rst), .opcode_i(opcode), .disp_i(disp),
        .br_addr_i(addr), .flags_i(flags), .ext_cond_i(ext),
        .taken_o(taken_b), .next_pc_o(npc_b)
    );

    // behavioural model of the requirements
    function automatic bit model_take(logic [9:0] op, logic [3:0] f, logic [3:0] e);
        bit s, z, o, c, r;
        s = f[3]; z = f[2]; o = f[1]; c = f[0];
        if (op[4]) return (op[3:0] == e);
        case (op[2:0])
            3'd0: r = 1;
            3'd1: r = c;
            3'd2: r = o;
            3'd3: r = !s;
            3'd4: r = z;
            3'd5: r = (s != o);
            3'd6: r = z || (s != o);
            default: r = (s != c);
        endcase
        if (op[3]) r = !r;
        return r;
    endfunction

    function automatic logic [15:0] model_pc(bit tk, logic [9:0] op, logic [15:0] d, logic [15:0] a);
        int v;
        if (!tk) v = int'(a) + 2;
        else if (op[5]) v = int'(a) + 1 - int'(d);
        else v = int'(a) + 2 + int'(d);
        v = v % 65536;
        if (v < 0) v = v + 65536;
        return 16'(v);
    endfunction

    function automatic string pick_tag(logic [9:0] op, bit tk);
        if (op[4]) return "R6";
        if (op[3:0] == 4'd0) return "R3";
        if (op[3]) return "R5";
        if (!tk) return "R4/R9";
        return op[5] ? "R4/R8" : "R4/R7";
    endfunction

    task automatic compare(string tag, bit etk, logic [15:0] epc);
        n_cmp++;
        if (taken_a !== etk || npc_a !== epc) begin
            n_bad++;
            $display("FAIL %s style0: taken=%0b pc=%04h expected taken=%0b pc=%04h",
                     tag, taken_a, npc_a, etk, epc);
        end
        n_cmp++;
        if (taken_b !== etk || npc_b !== epc) begin
            n_bad++;
            $display("FAIL %s style1: taken=%0b pc=%04h expected taken=%0b pc=%04h",
                     tag, taken_b, npc_b, etk, epc);
        end
    endtask

    // called at a falling edge; outputs are checked one full cycle later (R2)
    task automatic step(logic [9:0] op, logic [15:0] d, logic [15:0] a,
                        logic [3:0] f, logic [3:0] e, string tag_in);
        bit etk;
        logic [15:0] epc;
        string tag;
        opcode = op; disp = d; addr = a; flags = f; ext = e;
        etk = model_take(op, f, e);
        epc = model_pc(etk, op, d, a);
        tag = (tag_in == "") ? pick_tag(op, etk) : tag_in;
        @(posedge clk);
        @(negedge clk);
        compare({tag, "/R2"}, etk, epc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        opcode = 10'h200; disp = 16'h0010; addr = 16'h1234;
        repeat (3) @(negedge clk);
        compare("R1", 1'b0, 16'h0000);
        rst = 1'b0;

        // R3 always, forward and backward
        step(10'h200, 16'h0005, 16'h1000, 4'h0, 4'h0, "R3/R7");
        step(10'h220, 16'h0005, 16'h1000, 4'h0, 4'h0, "R3/R8");
        // R5 never: falls through past the displacement word
        step(10'h208, 16'h0777, 16'h4000, 4'hF, 4'h8, "R5/R9");
        // R4 per-code tests
        step(10'h201, 16'h0003, 16'h2000, 4'b0001, 4'h0, "R4");
        step(10'h201, 16'h0003, 16'h2000, 4'b1110, 4'h0, "R4");
        step(10'h203, 16'h0003, 16'h2000, 4'b0000, 4'h0, "R4");
        step(10'h206, 16'h0003, 16'h2000, 4'b0100, 4'h0, "R4");
        step(10'h207, 16'h0003, 16'h2000, 4'b1000, 4'h0, "R4");
        step(10'h20E, 16'h0003, 16'h2000, 4'b0100, 4'h0, "R5");
        // R6 external mode, flags do not matter
        step(10'h21A, 16'h0020, 16'h3000, 4'h0, 4'hA, "R6");
        step(10'h21A, 16'h0020, 16'h3000, 4'hF, 4'hB, "R6");
        step(10'h230, 16'h0020, 16'h3000, 4'h5, 4'h0, "R6/R8");
        // R10 wrap-around
        step(10'h200, 16'h0001, 16'hFFFE, 4'h0, 4'h0, "R10/R7");
        step(10'h220, 16'h0005, 16'h0002, 4'h0, 4'h0, "R10/R8");
        step(10'h208, 16'h0000, 16'hFFFF, 4'h0, 4'h0, "R10/R9");
        step(10'h220, 16'h0000, 16'hFFFF, 4'h0, 4'h0, "R10/R8");
        // R11 upper opcode bits and external input in flag mode ignored
        step(10'h3C1, 16'h0040, 16'h5000, 4'b0001, 4'h1, "R11");
        step(10'h001, 16'h0040, 16'h5000, 4'b0001, 4'hE, "R11");
        step(10'h109, 16'h0040, 16'h5000, 4'b0001, 4'h9, "R11");

        // random sweep over all codes and both modes
        for (int i = 0; i < 600; i++) begin
            step(10'($urandom), 16'($urandom), 16'($urandom),
                 4'($urandom), 4'($urandom), "");
        end

        // R1 mid-run reset overrides a taken branch
        opcode = 10'h200; disp = 16'h0100; addr = 16'h0200;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare("R1", 1'b0, 16'h0000);
        rst = 1'b0;
        step(10'h200, 16'h0100, 16'h0200, 4'h0, 4'h0, "R3/R7");

        finish_run();
    end

endmodule